// File: doc/BRIEF.md
# Serial Stereo Audio Receiver with Slot-Width Detection

This block sits at the edge of an audio path and turns a three-wire serial stream into parallel stereo samples. The stream is a bit clock, one data line and one frame-select line. The frame-select line marks which channel the current slot belongs to. The block runs entirely on the bit clock. It measures how many bit clocks each stereo frame spans, and from that count it decides without any programming whether slots are 16 or 32 clocks wide. It then delivers one left/right pair per frame, together with a one-cycle strobe.

Two static settings come from a register block. One setting swaps which frame-select level means left. The other inserts a one-clock gap between the frame-select edge and the first data bit. With these two settings the block accepts plain I2S and its common left-justified variants. Both settings are meant to change only while the block is held in reset. Samples are always 32 bits wide. A 16-bit word is placed in the upper half of the sample.

Top module: `i2s_rx_auto`

## Requirements
- R1: While rst_n is low, valid_o is 0, left_o and right_o are all zeros, and long_fmt_o is 1, meaning 32-clock slots.
- R2: Data is sampled on rising bclk edges, most significant bit first. With cfg_delay_i = 0, the first data bit of a slot is the one sampled on the same edge where a new frame-select level is first seen.
- R3: With cfg_delay_i = 1, the first data bit of a slot is sampled one edge later than in R2. The last bit of each slot is then sampled on the first edge of the following slot.
- R4: In 16-clock mode the received word is placed in bits 31:16 of the sample, and bits 15:0 are zero.
- R5: With cfg_swap_i = 0, a frame-select level of 0 marks the left slot. With cfg_swap_i = 1, a level of 0 marks the right slot. A frame is one left slot followed by one right slot.
- R6: valid_o is high for exactly one bclk cycle. It rises in the cycle after the edge on which the frame-select change that ends a frame's right slot is sampled.
- R7: left_o and right_o change only together with a valid_o pulse. Between pulses they hold their values.
- R8: A frame of 32 bit clocks is classed as 16-clock slots, and a frame of 64 bit clocks as 32-clock slots. long_fmt_o changes to a new class only after two consecutive frames are classed the same way.
- R9: A frame whose class differs from the mode committed at its end produces no pulse. This includes the frame that commits a mode change.
- R10: A frame of any other length produces no pulse and leaves long_fmt_o unchanged. It also breaks the two-frame agreement of R8.
- R11: The slot in progress when reset is released is discarded. A right slot that has no preceding complete left slot produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Serial bit clock; every register in the block uses its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sd_i | input | 1 | Serial audio data |
| fs_i | input | 1 | Frame-select line; its level names the channel of the current slot |
| cfg_swap_i | input | 1 | 1 selects frame-select low as the right channel |
| cfg_delay_i | input | 1 | 1 inserts a one-clock gap before the first data bit |
| left_o | output | OUT_W | Most recent left sample |
| right_o | output | OUT_W | Most recent right sample |
| valid_o | output | 1 | One-cycle strobe for a new sample pair |
| long_fmt_o | output | 1 | Committed slot width: 1 for 32 clocks, 0 for 16 clocks |

## Verification
The stimulus covers all four combinations of polarity and delay, in both slot widths. Random words are used together with walking-edge words such as 0x80000001. These separate a dropped or shifted most significant bit from a lost last bit. The bench also sends mixed sequences: a lone long frame inside a run of short frames, a long frame after a frame of illegal length, and then two agreeing long frames. These check that the mode commits only on agreement and that the pulse is withheld for mismatched frames. Streams of only illegal-length frames, and a right slot straight after reset, show that nothing is emitted from partial or malformed frames. Every pulse is also checked for the exact cycle in which it appears.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;

   // committed or measured slot class
   typedef enum logic {
      SLOT_SHORT = 1'b0,
      SLOT_LONG  = 1'b1
   } slot_fmt_e;

endpackage

// File: rtl/i2s_slot_timer.sv
// Tracks frame-select changes and counts bit clocks since the last change.
module i2s_slot_timer #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fs_i,
   output logic             fs_q_o,
   output logic             edge_o,
   output logic             synced_o,
   output logic [CNT_W-1:0] cnt_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic primed;

   // a change is only meaningful once the previous level has been loaded
   assign edge_o = primed && (fs_i != fs_q_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         primed   <= 1'b0;
         fs_q_o   <= 1'b0;
         synced_o <= 1'b0;
         cnt_o    <= '0;
      end else begin
         primed <= 1'b1;
         fs_q_o <= fs_i;
         if (edge_o) begin
            cnt_o    <= '0;
            synced_o <= 1'b1;
         end else if (cnt_o != CNT_MAX) begin
            cnt_o <= cnt_o + CNT_W'(1);
         end
      end
   end

endmodule

// File: rtl/i2s_slot_shift.sv
// Per-bit capture of one slot word, MSB aligned at bit OUT_W-1.
module i2s_slot_shift #(
   parameter int OUT_W      = 32,
   parameter int SHORT_SLOT = 16,
   parameter int LONG_SLOT  = 32,
   parameter int CNT_W      = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sd_i,
   input  logic             edge_i,
   input  logic             delay_i,
   input  logic             long_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic [OUT_W-1:0] word_o
);

   int   slot_w;
   int   pos;
   int   k_new;
   int   k_tail;
   logic cap_new;
   logic tail_en;

   always_comb begin
      slot_w  = long_i ? LONG_SLOT : SHORT_SLOT;
      pos     = edge_i ? 0 : int'(cnt_i) + 1;
      k_new   = pos - int'(delay_i);
      cap_new = !edge_i && (k_new >= 0) && (k_new < slot_w);
      k_tail  = int'(cnt_i);
      // with the gap enabled the old slot's last bit rides on the change edge
      tail_en = edge_i && delay_i && (k_tail < slot_w);
   end

   for (genvar b = 0; b < OUT_W; b++) begin : g_bit
      localparam int K = OUT_W - 1 - b;
      logic bit_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bit_q <= 1'b0;
         end else if (edge_i) begin
            bit_q <= (K == 0) ? (sd_i & ~delay_i) : 1'b0;
         end else if (cap_new && (k_new == K)) begin
            bit_q <= sd_i;
         end
      end

      assign word_o[b] = (tail_en && (k_tail == K)) ? sd_i : bit_q;
   end

endmodule

// File: rtl/i2s_fmt_detect.sv
// Classifies each frame length and commits a mode on two agreeing frames.
module i2s_fmt_detect
   import i2s_rx_pkg::*;
#(
   parameter int SHORT_SLOT = 16,
   parameter int LONG_SLOT  = 32,
   parameter int LEN_W      = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_end_i,
   input  logic [LEN_W-1:0] frame_len_i,
   output logic             long_o,
   output logic             match_o
);

   localparam logic [LEN_W-1:0] SHORT_FRAME = LEN_W'(2 * SHORT_SLOT);
   localparam logic [LEN_W-1:0] LONG_FRAME  = LEN_W'(2 * LONG_SLOT);

   slot_fmt_e committed;
   slot_fmt_e prev_fmt;
   slot_fmt_e meas_fmt;
   logic      prev_hit;
   logic      meas_hit;

   always_comb begin
      meas_hit = (frame_len_i == SHORT_FRAME) || (frame_len_i == LONG_FRAME);
      meas_fmt = (frame_len_i == LONG_FRAME) ? SLOT_LONG : SLOT_SHORT;
      match_o  = meas_hit && (meas_fmt == committed);
   end

   assign long_o = (committed == SLOT_LONG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         committed <= SLOT_LONG;
         prev_fmt  <= SLOT_LONG;
         prev_hit  <= 1'b0;
      end else if (frame_end_i) begin
         prev_hit <= meas_hit;
         prev_fmt <= meas_fmt;
         if (meas_hit && prev_hit && (prev_fmt == meas_fmt)) begin
            committed <= meas_fmt;
         end
      end
   end

endmodule

// File: rtl/i2s_rx_auto.sv
module i2s_rx_auto
   import i2s_rx_pkg::*;
#(
   parameter int OUT_W      = 32,
   parameter int SHORT_SLOT = 16,
   parameter int LONG_SLOT  = 32,
   parameter int CNT_W      = 7
) (
   input  logic             bclk,
   input  logic             rst_n,
   input  logic             sd_i,
   input  logic             fs_i,
   input  logic             cfg_swap_i,
   input  logic             cfg_delay_i,
   output logic [OUT_W-1:0] left_o,
   output logic [OUT_W-1:0] right_o,
   output logic             valid_o,
   output logic             long_fmt_o
);

   localparam int LEN_W = CNT_W + 2;

   if (OUT_W < LONG_SLOT) begin : g_bad_out_w
      $error("OUT_W must hold a long slot");
   end
   if (SHORT_SLOT >= LONG_SLOT) begin : g_bad_slots
      $error("SHORT_SLOT must be below LONG_SLOT");
   end
   if ((2 ** CNT_W) <= LONG_SLOT) begin : g_bad_cnt_w
      $error("CNT_W too small for LONG_SLOT");
   end

   logic             fs_q;
   logic             fs_edge;
   logic             synced;
   logic [CNT_W-1:0] cnt;
   logic [OUT_W-1:0] slot_word;
   logic             mode_match;
   logic             long_mode;

   logic [OUT_W-1:0] left_hold;
   logic [LEN_W-1:0] left_len;
   logic             have_left;
   logic [LEN_W-1:0] slot_len;
   logic [LEN_W-1:0] frame_len;
   logic             old_is_left;
   logic             frame_end;

   i2s_slot_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (bclk),
      .rst_n    (rst_n),
      .fs_i     (fs_i),
      .fs_q_o   (fs_q),
      .edge_o   (fs_edge),
      .synced_o (synced),
      .cnt_o    (cnt)
   );

   i2s_slot_shift #(
      .OUT_W      (OUT_W),
      .SHORT_SLOT (SHORT_SLOT),
      .LONG_SLOT  (LONG_SLOT),
      .CNT_W      (CNT_W)
   ) u_shift (
      .clk     (bclk),
      .rst_n   (rst_n),
      .sd_i    (sd_i),
      .edge_i  (fs_edge),
      .delay_i (cfg_delay_i),
      .long_i  (long_mode),
      .cnt_i   (cnt),
      .word_o  (slot_word)
   );

   always_comb begin
      slot_len    = LEN_W'(cnt) + LEN_W'(1);
      frame_len   = left_len + slot_len;
      old_is_left = (fs_q == cfg_swap_i);
      frame_end   = fs_edge && synced && !old_is_left && have_left;
   end

   i2s_fmt_detect #(
      .SHORT_SLOT (SHORT_SLOT),
      .LONG_SLOT  (LONG_SLOT),
      .LEN_W      (LEN_W)
   ) u_detect (
      .clk         (bclk),
      .rst_n       (rst_n),
      .frame_end_i (frame_end),
      .frame_len_i (frame_len),
      .long_o      (long_mode),
      .match_o     (mode_match)
   );

   assign long_fmt_o = long_mode;

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         left_hold <= '0;
         left_len  <= '0;
         have_left <= 1'b0;
      end else if (fs_edge && synced) begin
         if (old_is_left) begin
            left_hold <= slot_word;
            left_len  <= slot_len;
            have_left <= 1'b1;
         end else begin
            have_left <= 1'b0;
         end
      end
   end

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         left_o  <= '0;
         right_o <= '0;
      end else begin
         valid_o <= frame_end && mode_match;
         if (frame_end && mode_match) begin
            left_o  <= left_hold;
            right_o <= slot_word;
         end
      end
   end

endmodule

// File: rtl/i2s_rx_auto_chk.sv
module i2s_rx_auto_chk #(
   parameter int OUT_W      = 32,
   parameter int SHORT_SLOT = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             valid,
   input logic             long_fmt,
   input logic [OUT_W-1:0] left,
   input logic [OUT_W-1:0] right
);

   // R6: strobe never lasts two cycles
   assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);

   // R9: the cycle a new mode becomes visible carries no strobe
   assert_mode_change_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(long_fmt) |-> !valid);

   // R4: short-mode samples have an empty lower part
   assert_short_low_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !long_fmt) |->
         ((left[OUT_W-SHORT_SLOT-1:0] == '0) && (right[OUT_W-SHORT_SLOT-1:0] == '0)));

   // R7: outputs are held while no strobe is present
   assert_hold_between_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> ($stable(left) && $stable(right)));

endmodule

bind i2s_rx_auto i2s_rx_auto_chk #(
   .OUT_W      (OUT_W),
   .SHORT_SLOT (SHORT_SLOT)
) u_chk (
   .clk      (bclk),
   .rst_n    (rst_n),
   .valid    (valid_o),
   .long_fmt (long_fmt_o),
   .left     (left_o),
   .right    (right_o)
);

// File: tb/i2s_rx_auto_tb.sv
module i2s_rx_auto_tb;

   localparam int CLK_PERIOD = 10;

   logic        bclk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sd = 1'b0;
   logic        fs = 1'b0;
   logic        swap = 1'b0;
   logic        dly = 1'b0;
   logic [31:0] left_o;
   logic [31:0] right_o;
   logic        valid_o;
   logic        long_fmt_o;

   i2s_rx_auto u_dut (
      .bclk        (bclk),
      .rst_n       (rst_n),
      .sd_i        (sd),
      .fs_i        (fs),
      .cfg_swap_i  (swap),
      .cfg_delay_i (dly),
      .left_o      (left_o),
      .right_o     (right_o),
      .valid_o     (valid_o),
      .long_fmt_o  (long_fmt_o)
   );

   always #(CLK_PERIOD/2) bclk = ~bclk;

   int cyc = 0;
   always @(posedge bclk) cyc <= cyc + 1;

   int          n_chk = 0;
   int          n_fail = 0;
   logic [31:0] exp_l [0:511];
   logic [31:0] exp_r [0:511];
   int          exp_c [0:511];
   string       exp_t [0:511];
   int          exp_n = 0;
   int          got_n = 0;
   bit          mdl_long;
   bit          mdl_prev_hit;
   bit          mdl_prev_fmt;
   bit          prev_lsb;
   int          seed_init;

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   function automatic logic [31:0] align(input int w, input logic [31:0] word);
      return (w == 16) ? {word[15:0], 16'h0000} : word;
   endfunction

   // compare every strobe with the next predicted pair and its cycle
   always @(negedge bclk) begin
      if (rst_n && valid_o) begin
         if (got_n >= exp_n) begin
            check(1'b0, "R9", "unexpected strobe", left_o, 32'h0);
         end else begin
            check(left_o == exp_l[got_n], exp_t[got_n], "left sample", left_o, exp_l[got_n]);
            check(right_o == exp_r[got_n], exp_t[got_n], "right sample", right_o, exp_r[got_n]);
            check(cyc == exp_c[got_n], "R6", "strobe cycle", cyc, exp_c[got_n]);
         end
         got_n++;
      end
   end

   task automatic do_reset(input bit s, input bit d, input bit idle_left);
      @(negedge bclk);
      rst_n = 1'b0;
      swap  = s;
      dly   = d;
      fs    = idle_left ? s : ~s;
      repeat (3) @(negedge bclk);
      check(valid_o == 1'b0, "R1", "reset strobe", {31'h0, valid_o}, 32'h0);
      check(left_o == 32'h0, "R1", "reset left", left_o, 32'h0);
      check(right_o == 32'h0, "R1", "reset right", right_o, 32'h0);
      check(long_fmt_o == 1'b1, "R1", "reset mode", {31'h0, long_fmt_o}, 32'h1);
      exp_n = 0;
      got_n = 0;
      mdl_long = 1'b1;
      mdl_prev_hit = 1'b0;
      mdl_prev_fmt = 1'b1;
      prev_lsb = 1'b0;
      rst_n = 1'b1;
      repeat (5) begin
         @(negedge bclk);
         sd = 1'($urandom);
      end
   endtask

   task automatic send_slot(input int w, input bit lvl, input logic [31:0] word);
      int k;
      for (int p = 0; p < w; p++) begin
         @(negedge bclk);
         fs = lvl;
         if (dly && p == 0) begin
            sd = prev_lsb;
         end else begin
            k  = p - (dly ? 1 : 0);
            sd = word[w - 1 - k];
         end
      end
      prev_lsb = word[0];
   endtask

   task automatic send_frame(input int w, input logic [31:0] l, input logic [31:0] r,
                             input string tag);
      bit hit;
      bit fmt;
      send_slot(w, swap, l);
      send_slot(w, ~swap, r);
      hit = (w == 16) || (w == 32);
      fmt = (w == 32);
      if (hit && (fmt == mdl_long)) begin
         exp_l[exp_n] = align(w, l);
         exp_r[exp_n] = align(w, r);
         exp_c[exp_n] = cyc + 2;
         exp_t[exp_n] = tag;
         exp_n++;
      end
      if (hit && mdl_prev_hit && (mdl_prev_fmt == fmt)) mdl_long = fmt;
      mdl_prev_hit = hit;
      mdl_prev_fmt = fmt;
   endtask

   task automatic rand_frames(input int n, input int w, input string tag);
      for (int i = 0; i < n; i++) send_frame(w, $urandom, $urandom, tag);
   endtask

   task automatic end_group(input string tag, input bit exp_long);
      send_slot(8, swap, $urandom);
      @(negedge bclk);
      check(got_n == exp_n, "R6", "strobe count", got_n, exp_n);
      check(long_fmt_o == exp_long, tag, "committed mode", {31'h0, long_fmt_o}, {31'h0, exp_long});
      if (exp_n > 0) begin
         check(left_o == exp_l[exp_n-1], "R7", "held left", left_o, exp_l[exp_n-1]);
         check(right_o == exp_r[exp_n-1], "R7", "held right", right_o, exp_r[exp_n-1]);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      seed_init = $urandom(32'd4711);
      // R2: plain format, long slots
      do_reset(1'b0, 1'b0, 1'b0);
      send_frame(32, 32'h8000_0001, 32'h7FFF_FFFE, "R2");
      send_frame(32, 32'h0000_0000, 32'hFFFF_FFFF, "R2");
      rand_frames(8, 32, "R2");
      end_group("R8", 1'b1);
      // R3: one-clock gap, long slots
      do_reset(1'b0, 1'b1, 1'b0);
      send_frame(32, 32'h8000_0001, 32'h7FFF_FFFE, "R3");
      send_frame(32, 32'h0000_0001, 32'h8000_0000, "R3");
      rand_frames(8, 32, "R3");
      end_group("R8", 1'b1);
      // R5: swapped polarity
      do_reset(1'b1, 1'b0, 1'b0);
      send_frame(32, 32'h1234_5678, 32'h9ABC_DEF0, "R5");
      rand_frames(8, 32, "R5");
      end_group("R8", 1'b1);
      // R4: short slots, first two frames withheld (R9)
      do_reset(1'b0, 1'b0, 1'b0);
      rand_frames(4, 16, "R4");
      send_frame(16, 32'h0000_8001, 32'h0000_7FFE, "R4");
      rand_frames(4, 16, "R4");
      end_group("R8", 1'b0);
      // R4 and R3 with swap
      do_reset(1'b1, 1'b1, 1'b0);
      send_frame(16, 32'h0000_8001, 32'h0000_0001, "R4");
      rand_frames(8, 16, "R4");
      end_group("R8", 1'b0);
      // R8: a single long frame does not commit
      do_reset(1'b0, 1'b0, 1'b0);
      rand_frames(3, 16, "R8");
      send_frame(32, $urandom, $urandom, "R9");
      rand_frames(2, 16, "R8");
      end_group("R8", 1'b0);
      // R10: an illegal frame breaks agreement
      do_reset(1'b0, 1'b1, 1'b0);
      rand_frames(3, 16, "R8");
      send_frame(32, $urandom, $urandom, "R9");
      send_frame(24, $urandom, $urandom, "R10");
      send_frame(32, $urandom, $urandom, "R9");
      end_group("R10", 1'b0);
      // R8: two agreeing long frames commit, third is delivered
      do_reset(1'b0, 1'b0, 1'b0);
      rand_frames(3, 16, "R8");
      rand_frames(3, 32, "R8");
      end_group("R8", 1'b1);
      // R10: only illegal frames
      do_reset(1'b1, 1'b0, 1'b0);
      rand_frames(4, 24, "R10");
      end_group("R10", 1'b1);
      // R11: lone right slot after reset is dropped
      do_reset(1'b0, 1'b0, 1'b1);
      send_slot(32, 1'b1, $urandom);
      rand_frames(4, 32, "R11");
      end_group("R11", 1'b1);
      summary();
      $finish;
   end

endmodule